// File: doc/BRIEF.md
# Exhaustive PLL Ratio Search Engine

This block picks the settings for a clock synthesiser whose output is a fixed reference frequency multiplied by M and divided by N and by a power of two, 2^P. Given a desired output frequency in kHz, it walks every legal (M, N, P) combination, computes the integer output frequency each one yields, and keeps the combination whose frequency is nearest to the request. When the walk ends it presents the winning M, N and P together with the frequency they produce.

A search is launched with a single-cycle `start` pulse while `busy` is low; the requested frequency is captured in that cycle. `busy` acts as the not-ready indication for the request: a `start` seen while `busy` is high is dropped and does not queue. The result fields change only during a search and then hold their values until the next accepted `start`. `done` marks the single cycle in which a fresh result becomes available. There is no back-pressure on the result, which simply stays put until it is replaced.

Internally the quotient of REF×M by N is produced once per (M, N) pair by a bit-serial divider, and the eight power-of-two variants are then scored one per cycle by shifting that quotient right. Because the divider always runs its full width, a search takes the same number of cycles for every target.

Top module: `pll_div_search`

## Requirements
- R1: A `start` pulse seen while `busy` is low is accepted, and `busy` reads high from the cycle after acceptance until the search ends.
- R2: Candidates cover M = 1..M_MAX (default 63), N = 1..N_MAX (default 7) and P = 0..P_MAX (default 7). They are visited with P stepping fastest, then N, then M. `m_sel`, `n_sel` and `p_sel` carry the plain binary values of M, N and the exponent P.
- R3: The frequency reported for a candidate is floor(REF_KHZ × M / (N × 2^P)), where REF_KHZ defaults to 13000. `freq_khz` equals this value for the returned `m_sel`, `n_sel` and `p_sel`.
- R4: The returned candidate has the smallest absolute difference between its frequency and the target, among all candidates.
- R5: When several candidates share that smallest difference, the one reached first in the R2 visiting order is returned.
- R6: `done` is high for exactly one cycle, following the scoring of the final candidate (M_MAX, N_MAX, P_MAX). `busy` is low in that cycle.
- R7: While the engine is idle and no `start` arrives, `m_sel`, `n_sel`, `p_sel` and `freq_khz` keep their values, whatever `target_khz` does.
- R8: A `start` seen while `busy` is high is ignored, and so is a change on `target_khz` after acceptance. The search finishes at its normal time with the result for the target captured at acceptance.
- R9: After reset, `busy` and `done` are low and the outputs read M=1, N=1, P=0, frequency 0.
- R10: The number of cycles from acceptance to `done` is the same for every target value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; accepted only while idle |
| target_khz | input | FREQ_W (20) | Requested output frequency in kHz, captured at acceptance |
| busy | output | 1 | High while a search runs; a request is not accepted |
| done | output | 1 | One-cycle pulse when the result is ready |
| m_sel | output | M_W (6) | Chosen multiplier M |
| n_sel | output | N_W (3) | Chosen divider N |
| p_sel | output | P_W (3) | Chosen post-divider exponent P |
| freq_khz | output | FREQ_W (20) | Frequency produced by the chosen settings, in kHz |

## Verification
The hardest behaviour to observe from the ports is the tie-break, because only the final winner is visible. The stimulus therefore uses targets that several candidates hit exactly, such as 13000 and 6500. With those targets, M=1, N=1, P=0 must beat the equal-valued M=2, N=2, P=0, and M=1, N=1, P=1 must beat M=1, N=2, P=0. A second hard case is a request that arrives mid-search. The bench injects a `start` carrying a different target part way through a run. It then checks that both the answer and the cycle count match an undisturbed search.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_DIV    = 2'd2,
    ST_SCAN   = 2'd3
  } srch_state_e;

  // Bits needed to hold the value v (at least one).
  function automatic int bits_for(input int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/pll_cand_iter.sv
module pll_cand_iter
  import pll_search_pkg::*;
#(
  parameter int M_MAX = 63,
  parameter int N_MAX = 7,
  parameter int P_MAX = 7,
  localparam int M_W = bits_for(M_MAX),
  localparam int N_W = bits_for(N_MAX),
  localparam int P_W = bits_for(P_MAX)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step_p,
  input  logic           step_mn,
  output logic [M_W-1:0] m,
  output logic [N_W-1:0] n,
  output logic [P_W-1:0] p,
  output logic           last_p,
  output logic           last_mn
);

  localparam logic [M_W-1:0] M_TOP = M_W'(M_MAX);
  localparam logic [N_W-1:0] N_TOP = N_W'(N_MAX);
  localparam logic [P_W-1:0] P_TOP = P_W'(P_MAX);

  assign last_p  = (p == P_TOP);
  assign last_mn = (m == M_TOP) && (n == N_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m <= M_W'(1);
      n <= N_W'(1);
      p <= '0;
    end else if (load) begin
      m <= M_W'(1);
      n <= N_W'(1);
      p <= '0;
    end else if (step_mn) begin
      p <= '0;
      if (n == N_TOP) begin
        n <= N_W'(1);
        m <= m + M_W'(1);
      end else begin
        n <= n + N_W'(1);
      end
    end else if (step_p) begin
      p <= p + P_W'(1);
    end
  end

  // R2: counters never leave their legal ranges
  p_m_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m >= M_W'(1)) && (m <= M_TOP));
  p_n_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (n >= N_W'(1)) && (n <= N_TOP));
  p_p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    p <= P_TOP);

  // R2: P is the innermost index
  p_inner_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_p && !load && !step_mn) |=> (p == $past(p) + P_W'(1)) && $stable(m) && $stable(n));

  // R2: N wraps into the next M
  p_n_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_mn && !load && n == N_TOP) |=> (n == N_W'(1)) && (m == $past(m) + M_W'(1)) && (p == '0));

endmodule

// File: rtl/pll_seq_div.sv
module pll_seq_div
  import pll_search_pkg::*;
#(
  parameter int NUM_W = 20,
  parameter int DEN_W = 3,
  localparam int CNT_W = bits_for(NUM_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic [NUM_W-1:0] quotient,
  output logic             fin
);

  logic [DEN_W-1:0] rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             fits;

  assign trial = {rem_q, quotient[NUM_W-1]};
  assign fits  = (trial >= {1'b0, divisor});
  assign diff  = trial - {1'b0, divisor};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quotient <= '0;
      rem_q    <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      fin      <= 1'b0;
    end else if (go) begin
      quotient <= dividend;
      rem_q    <= '0;
      cnt_q    <= CNT_W'(NUM_W);
      run_q    <= 1'b1;
      fin      <= 1'b0;
    end else if (run_q) begin
      if (fits) begin
        rem_q    <= diff[DEN_W-1:0];
        quotient <= {quotient[NUM_W-2:0], 1'b1};
      end else begin
        rem_q    <= trial[DEN_W-1:0];
        quotient <= {quotient[NUM_W-2:0], 1'b0};
      end
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        run_q <= 1'b0;
        fin   <= 1'b1;
      end
    end else begin
      fin <= 1'b0;
    end
  end

  // R3: a finished division leaves a remainder below the divisor
  p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (rem_q < divisor));
  // R2: N is never zero when a division is launched
  p_den_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (divisor != '0));
  p_fin_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);

endmodule

// File: rtl/pll_best_track.sv
module pll_best_track
  import pll_search_pkg::*;
#(
  parameter int FREQ_W = 20,
  parameter int M_W = 6,
  parameter int N_W = 3,
  parameter int P_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              eval,
  input  logic [M_W-1:0]    cand_m,
  input  logic [N_W-1:0]    cand_n,
  input  logic [P_W-1:0]    cand_p,
  input  logic [FREQ_W-1:0] cand_freq,
  input  logic [FREQ_W-1:0] target,
  output logic [M_W-1:0]    best_m,
  output logic [N_W-1:0]    best_n,
  output logic [P_W-1:0]    best_p,
  output logic [FREQ_W-1:0] best_freq
);

  logic [FREQ_W-1:0] best_err;
  logic [FREQ_W-1:0] cand_err;
  logic              better;

  assign cand_err = (cand_freq > target) ? (cand_freq - target) : (target - cand_freq);
  assign better   = (cand_err < best_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_err  <= '1;
      best_m    <= M_W'(1);
      best_n    <= N_W'(1);
      best_p    <= '0;
      best_freq <= '0;
    end else if (clear) begin
      best_err  <= '1;
      best_m    <= M_W'(1);
      best_n    <= N_W'(1);
      best_p    <= '0;
      best_freq <= '0;
    end else if (eval && better) begin
      best_err  <= cand_err;
      best_m    <= cand_m;
      best_n    <= cand_n;
      best_p    <= cand_p;
      best_freq <= cand_freq;
    end
  end

  // R4: the held error never grows during a search
  p_err_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !clear) |=> (best_err <= $past(best_err)));
  // R5: an equal error keeps the earlier candidate
  p_tie_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !clear && cand_err == best_err) |=>
      ($stable(best_m) && $stable(best_n) && $stable(best_p) && $stable(best_freq)));

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int REF_KHZ = 13000,
  parameter int M_MAX = 63,
  parameter int N_MAX = 7,
  parameter int P_MAX = 7,
  localparam int M_W = bits_for(M_MAX),
  localparam int N_W = bits_for(N_MAX),
  localparam int P_W = bits_for(P_MAX),
  localparam int FREQ_W = bits_for(REF_KHZ * M_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] target_khz,
  output logic              busy,
  output logic              done,
  output logic [M_W-1:0]    m_sel,
  output logic [N_W-1:0]    n_sel,
  output logic [P_W-1:0]    p_sel,
  output logic [FREQ_W-1:0] freq_khz
);

  srch_state_e       st_q, st_d;
  logic [FREQ_W-1:0] tgt_q;
  logic              accept;
  logic              in_scan;
  logic [M_W-1:0]    cur_m;
  logic [N_W-1:0]    cur_n;
  logic [P_W-1:0]    cur_p;
  logic              last_p, last_mn;
  logic [FREQ_W-1:0] dividend;
  logic [FREQ_W-1:0] div_quo;
  logic              div_fin;
  logic [FREQ_W-1:0] cand_freq;

  assign accept   = (st_q == ST_IDLE) && start;
  assign in_scan  = (st_q == ST_SCAN);
  assign busy     = (st_q != ST_IDLE);
  assign dividend = FREQ_W'(REF_KHZ) * FREQ_W'(cur_m);
  assign cand_freq = div_quo >> cur_p;

  pll_cand_iter #(
    .M_MAX(M_MAX), .N_MAX(N_MAX), .P_MAX(P_MAX)
  ) u_iter (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .step_p  (in_scan && !last_p),
    .step_mn (in_scan && last_p && !last_mn),
    .m       (cur_m),
    .n       (cur_n),
    .p       (cur_p),
    .last_p  (last_p),
    .last_mn (last_mn)
  );

  pll_seq_div #(
    .NUM_W(FREQ_W), .DEN_W(N_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (st_q == ST_LAUNCH),
    .dividend (dividend),
    .divisor  (cur_n),
    .quotient (div_quo),
    .fin      (div_fin)
  );

  pll_best_track #(
    .FREQ_W(FREQ_W), .M_W(M_W), .N_W(N_W), .P_W(P_W)
  ) u_best (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .eval      (in_scan),
    .cand_m    (cur_m),
    .cand_n    (cur_n),
    .cand_p    (cur_p),
    .cand_freq (cand_freq),
    .target    (tgt_q),
    .best_m    (m_sel),
    .best_n    (n_sel),
    .best_p    (p_sel),
    .best_freq (freq_khz)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start) st_d = ST_LAUNCH;
      ST_LAUNCH: st_d = ST_DIV;
      ST_DIV:    if (div_fin) st_d = ST_SCAN;
      ST_SCAN: begin
        if (last_p) st_d = last_mn ? ST_IDLE : ST_LAUNCH;
      end
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tgt_q <= '0;
      done  <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= in_scan && last_p && last_mn;
      if (accept) tgt_q <= target_khz;
    end
  end

  // R6: completion is a single-cycle pulse seen while idle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R1: an accepted request makes the engine busy
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  // R7: results hold while idle without a request
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(m_sel) && $stable(n_sel) && $stable(p_sel) && $stable(freq_khz)));
  // R8: the captured target is frozen for the whole search
  p_target_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(tgt_q));

endmodule

// File: tb/tb_pll_div_search.sv
`timescale 1ns/1ps
module tb_pll_div_search;

  localparam int REF = 13000;
  localparam int MM = 63;
  localparam int NM = 7;
  localparam int PM = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] target_khz = '0;
  logic        busy, done;
  logic [5:0]  m_sel;
  logic [2:0]  n_sel, p_sel;
  logic [19:0] freq_khz;

  int checks = 0;
  int failures = 0;
  int base_lat = -1;

  always #5 clk = ~clk;

  pll_div_search dut (
    .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
    .busy(busy), .done(done), .m_sel(m_sel), .n_sel(n_sel),
    .p_sel(p_sel), .freq_khz(freq_khz)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic ref_search(input int tgt, output int bm, output int bn, output int bp, output int bf);
    int best_err;
    best_err = 32'h7fffffff;
    bm = 1; bn = 1; bp = 0; bf = 0;
    for (int m = 1; m <= MM; m++)
      for (int n = 1; n <= NM; n++)
        for (int p = 0; p <= PM; p++) begin
          int f, e;
          f = (REF * m) / (n * (1 << p));
          e = (f > tgt) ? f - tgt : tgt - f;
          if (e < best_err) begin
            best_err = e; bm = m; bn = n; bp = p; bf = f;
          end
        end
  endtask

  // Runs one search; inject > 0 sends a second start with another target mid-run.
  task automatic run_search(input int tgt, input int inject, output int lat);
    bit seen;
    @(negedge clk);
    start = 1'b1;
    target_khz = 20'(tgt);
    @(negedge clk);
    start = 1'b0;
    chk("R1", "busy after accept", int'(busy), 1);
    lat = 1;
    seen = 0;
    while (!seen && lat < 20000) begin
      if (done) begin
        seen = 1;
      end else begin
        if (inject > 0 && lat == inject) begin
          start = 1'b1;
          target_khz = 20'd6500;
        end else if (inject > 0 && lat == inject + 1) begin
          start = 1'b0;
          target_khz = 20'd819000;
        end
        @(negedge clk);
        lat++;
      end
    end
    if (!seen) begin
      failures++;
      checks++;
      $display("FAIL R6 watchdog actual=no_done expected=done");
    end
    chk("R6", "busy low with done", int'(busy), 0);
    @(negedge clk);
    chk("R6", "done single cycle", int'(done), 0);
  endtask

  task automatic verify(input int tgt, input int lat);
    int em, en, ep, ef;
    ref_search(tgt, em, en, ep, ef);
    chk("R4", $sformatf("m for %0d", tgt), int'(m_sel), em);
    chk("R5", $sformatf("n for %0d", tgt), int'(n_sel), en);
    chk("R5", $sformatf("p for %0d", tgt), int'(p_sel), ep);
    chk("R3", $sformatf("freq for %0d", tgt), int'(freq_khz),
        (REF * int'(m_sel)) / (int'(n_sel) * (1 << int'(p_sel))));
    chk("R4", $sformatf("freq ref for %0d", tgt), int'(freq_khz), ef);
    if (base_lat < 0) base_lat = lat;
    else chk("R10", $sformatf("latency for %0d", tgt), lat, base_lat);
  endtask

  initial begin
    #2_000_000;
    failures++;
    checks++;
    $display("FAIL R6 global watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat;
    int hm, hn, hp, hf;
    int targets[6] = '{13000, 6500, 25000, 1, 819000, 50000};
    repeat (3) @(negedge clk);
    // R9: reset values
    chk("R9", "busy", int'(busy), 0);
    chk("R9", "done", int'(done), 0);
    chk("R9", "m", int'(m_sel), 1);
    chk("R9", "n", int'(n_sel), 1);
    chk("R9", "p", int'(p_sel), 0);
    chk("R9", "freq", int'(freq_khz), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4, R5 (ties at 13000 and 6500), R2 ordering, R3, R10
    foreach (targets[i]) begin
      run_search(targets[i], 0, lat);
      verify(targets[i], lat);
    end
    // R5: explicit tie expectations
    run_search(6500, 0, lat);
    chk("R5", "tie 6500 n", int'(n_sel), 1);
    chk("R5", "tie 6500 p", int'(p_sel), 1);
    chk("R2", "tie 6500 m", int'(m_sel), 1);

    // R7: outputs hold in idle while target wiggles
    hm = int'(m_sel); hn = int'(n_sel); hp = int'(p_sel); hf = int'(freq_khz);
    for (int k = 0; k < 40; k++) begin
      target_khz = 20'(k * 977);
      @(negedge clk);
    end
    chk("R7", "hold m", int'(m_sel), hm);
    chk("R7", "hold n", int'(n_sel), hn);
    chk("R7", "hold p", int'(p_sel), hp);
    chk("R7", "hold freq", int'(freq_khz), hf);
    chk("R7", "idle busy", int'(busy), 0);

    // R8: start and target change mid-search are ignored
    run_search(25000, 500, lat);
    chk("R8", "latency unchanged", lat, base_lat);
    verify(25000, lat);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule